// File: doc/BRIEF.md
# Dual BCD Digit Strobe Driver

This block takes one packed byte holding two BCD digits and writes it into two latched decimal displays. The displays hang off one shared 4-bit data bus, and each display has its own active-low latch strobe. On a write request the block puts the units digit on the bus and pulses the units strobe. It then does the same with the tenths digit and the tenths strobe. When both digits are latched it raises a one-cycle done pulse.

Each digit goes through three phases. In the setup phase the bus carries the digit while the strobe is still high. In the low phase the strobe is held low for `STB_LOW_CYCLES` clocks. In the hold phase the strobe is high again and the bus still carries the digit. When the block is idle, the bus and both strobes rest at logic one. A request that arrives while a sequence is running has no effect.

Top module: `dual_digit_strobe`

## Requirements
- R1: While reset is asserted and right after it is released, both strobes are high, busy and done are low, and the bus reads 4'hF.
- R2: A write request sampled while idle is accepted at that clock edge, and busy is high in the very next cycle.
- R3: The units digit is written first. It is taken from bits [7:4] of the byte and latched with `units_stb_n`.
- R4: The tenths digit is written second. It is taken from bits [3:0] of the byte and latched with `tenths_stb_n`.
- R5: The two strobes are never low in the same cycle, and neither strobe is low while busy is low.
- R6: The bus carries a digit for exactly one cycle before that digit's strobe falls.
- R7: In the cycle after a strobe rises, the bus still carries the same digit.
- R8: Each strobe stays low for exactly `STB_LOW_CYCLES` consecutive cycles. The minimum value of this parameter is 1.
- R9: Busy stays high for 2*(`STB_LOW_CYCLES`+2) cycles. Done is high for exactly one cycle: the first cycle in which busy is low again.
- R10: Whenever busy is low, the bus reads 4'hF, so all four data lines are driven high.
- R11: A write request or byte change while busy is ignored. The running sequence still presents the original digits, and no extra sequence follows it.
- R12: A request made in the done cycle is accepted, so two writes can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request, sampled while idle |
| wr_byte | input | 8 | Packed BCD byte: units digit in [7:4], tenths digit in [3:0] |
| bus_nib | output | 4 | Shared digit data bus, 4'hF when idle |
| units_stb_n | output | 1 | Active-low latch strobe of the units display |
| tenths_stb_n | output | 1 | Active-low latch strobe of the tenths display |
| busy | output | 1 | High while a two-digit sequence runs |
| done | output | 1 | One-cycle pulse after both digits are latched |

## Verification
A wrong digit select or wrong byte capture shows at the ports within two cycles of acceptance. At that point the setup phase puts a nibble on the bus, and the wrong value can be seen there. A low-phase counter that stops early or overruns shows up as a strobe whose low width is wrong, and this is visible at the cycle the strobe rises. A phase register that skips the setup or hold phase shows up as a bus change next to a strobe edge, or as a busy span of the wrong length. A request that leaks in while busy shows up as wrong digits or as a second sequence after done.

// File: rtl/bsd_pkg.sv
`timescale 1ns/1ps
package bsd_pkg;
  localparam int NIB_W    = 4;
  localparam int N_DIGITS = 2;
  localparam logic [NIB_W-1:0] BUS_IDLE = '1;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} phase_t;

  // digit 0 (units) lives in the upper nibble, digit 1 (tenths) in the lower
  function automatic logic [NIB_W-1:0] digit_nibble(input logic [2*NIB_W-1:0] b,
                                                    input logic idx);
    return idx ? b[NIB_W-1:0] : b[2*NIB_W-1:NIB_W];
  endfunction

  // total busy cycles for one write: per digit setup + low + hold
  function automatic int busy_cycles(input int low_cycles);
    return N_DIGITS * (low_cycles + 2);
  endfunction
endpackage

// File: rtl/bsd_low_timer.sv
`timescale 1ns/1ps
module bsd_low_timer #(
  parameter int LOW_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = (LOW_CYCLES > 1) ? $clog2(LOW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOW_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || expire) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/bsd_seq.sv
`timescale 1ns/1ps
module bsd_seq
  import bsd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_req,
  input  logic [2*NIB_W-1:0]   wr_byte,
  input  logic                 low_expire,
  output phase_t               phase,
  output logic                 digit_sel,
  output logic [2*NIB_W-1:0]   byte_q,
  output logic                 accept,
  output logic                 done
);
  localparam logic LAST_DIGIT = 1'(N_DIGITS - 1);

  assign accept = (phase == PH_IDLE) && wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      digit_sel <= 1'b0;
      byte_q    <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (accept) begin
          byte_q    <= wr_byte;
          digit_sel <= 1'b0;
          phase     <= PH_SETUP;
        end
        PH_SETUP: phase <= PH_LOW;
        PH_LOW:   if (low_expire) phase <= PH_HOLD;
        PH_HOLD: begin
          if (digit_sel == LAST_DIGIT) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            digit_sel <= digit_sel + 1'b1;
            phase     <= PH_SETUP;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsd_bus_drive.sv
`timescale 1ns/1ps
module bsd_bus_drive
  import bsd_pkg::*;
(
  input  phase_t               phase,
  input  logic                 digit_sel,
  input  logic [2*NIB_W-1:0]   byte_q,
  output logic [NIB_W-1:0]     bus,
  output logic [N_DIGITS-1:0]  stb_n
);
  assign bus = (phase == PH_IDLE) ? BUS_IDLE : digit_nibble(byte_q, digit_sel);

  for (genvar i = 0; i < N_DIGITS; i++) begin : g_stb
    assign stb_n[i] = !((phase == PH_LOW) && (digit_sel == 1'(i)));
  end
endmodule

// File: rtl/dual_digit_strobe.sv
`timescale 1ns/1ps
module dual_digit_strobe
  import bsd_pkg::*;
#(
  parameter int STB_LOW_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_req,
  input  logic [7:0] wr_byte,
  output logic [3:0] bus_nib,
  output logic       units_stb_n,
  output logic       tenths_stb_n,
  output logic       busy,
  output logic       done
);
  phase_t               phase_w;
  logic                 sel_w;
  logic [2*NIB_W-1:0]   byte_w;
  logic                 accept_w;
  logic                 low_expire_w;
  logic                 low_run_w;
  logic [N_DIGITS-1:0]  stb_n_w;

  assign low_run_w = (phase_w == PH_LOW);

  bsd_low_timer #(.LOW_CYCLES(STB_LOW_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(low_run_w), .expire(low_expire_w)
  );

  bsd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_byte(wr_byte),
    .low_expire(low_expire_w), .phase(phase_w), .digit_sel(sel_w),
    .byte_q(byte_w), .accept(accept_w), .done(done)
  );

  bsd_bus_drive u_drive (
    .phase(phase_w), .digit_sel(sel_w), .byte_q(byte_w),
    .bus(bus_nib), .stb_n(stb_n_w)
  );

  assign units_stb_n  = stb_n_w[0];
  assign tenths_stb_n = stb_n_w[1];
  assign busy         = (phase_w != PH_IDLE);
endmodule

// File: rtl/bsd_chk.sv
`timescale 1ns/1ps
module bsd_chk
  import bsd_pkg::*;
#(
  parameter int LOW_CYCLES = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] bus,
  input logic       units_n,
  input logic       tenths_n,
  input logic       busy,
  input logic       done,
  input logic       accept
);
  logic        any_low;
  logic [15:0] low_run;
  logic [15:0] busy_run;
  logic        units_seen;

  assign any_low = !(units_n && tenths_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run    <= '0;
      busy_run   <= '0;
      units_seen <= 1'b0;
    end else begin
      low_run  <= any_low ? low_run + 16'd1 : 16'd0;
      busy_run <= busy ? busy_run + 16'd1 : 16'd0;
      if (done)          units_seen <= 1'b0;
      else if (!units_n) units_seen <= 1'b1;
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && units_n && tenths_n);

  p_units_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tenths_n) |-> units_seen);

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    units_n || tenths_n);

  p_idle_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (units_n && tenths_n));

  p_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(units_n) || $fell(tenths_n)) |-> $stable(bus));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(units_n) || $rose(tenths_n)) |-> $stable(bus));

  p_low_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(units_n) || $rose(tenths_n)) |-> (low_run == 16'(LOW_CYCLES)));

  p_busy_span_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && busy_run == 16'(busy_cycles(LOW_CYCLES))));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus == BUS_IDLE));
endmodule

bind dual_digit_strobe bsd_chk #(.LOW_CYCLES(STB_LOW_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus(bus_nib), .units_n(units_stb_n),
  .tenths_n(tenths_stb_n), .busy(busy), .done(done), .accept(accept_w)
);

// File: tb/tb_dual_digit_strobe.sv
`timescale 1ns/1ps
module tb_dual_digit_strobe;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req [2];
  logic [7:0] wb  [2];
  logic [3:0] bus [2];
  logic       un  [2];
  logic       tn  [2];
  logic       bsy [2];
  logic       dn  [2];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_digit_strobe #(.STB_LOW_CYCLES(3)) dut (
    .clk(clk), .rst_n(rst_n), .wr_req(req[0]), .wr_byte(wb[0]),
    .bus_nib(bus[0]), .units_stb_n(un[0]), .tenths_stb_n(tn[0]),
    .busy(bsy[0]), .done(dn[0])
  );

  dual_digit_strobe #(.STB_LOW_CYCLES(1)) dut1 (
    .clk(clk), .rst_n(rst_n), .wr_req(req[1]), .wr_byte(wb[1]),
    .bus_nib(bus[1]), .units_stb_n(un[1]), .tenths_stb_n(tn[1]),
    .busy(bsy[1]), .done(dn[1])
  );

  function automatic int low_of(input int k);
    return (k == 0) ? 3 : 1;
  endfunction

  // vector layout: {bus, units_n, tenths_n, busy, done}
  task automatic chk(input int k, input string tag, input int cyc, input logic [7:0] exp);
    logic [7:0] act;
    act = {bus[k], un[k], tn[k], bsy[k], dn[k]};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dut%0d cycle %0d: got %h expected %h", tag, k, cyc, act, exp);
    end
  endtask

  // one full write; pfx tags the scenario, poke holds a request and a junk byte while busy
  task automatic write_seq(input int k, input logic [7:0] b, input string pfx,
                           input bit poke, input bit tail);
    int L;
    int total;
    L = low_of(k);
    total = 2 * (L + 2);
    req[k] = 1'b1;
    wb[k]  = b;
    @(posedge clk);
    @(negedge clk);
    if (poke) wb[k] = ~b;
    else      req[k] = 1'b0;
    for (int cyc = 1; cyc <= total; cyc++) begin
      int d;
      int pos;
      bit lo;
      logic [3:0] nib;
      string tag;
      d   = (cyc - 1) / (L + 2);
      pos = (cyc - 1) % (L + 2);
      lo  = (pos >= 1) && (pos <= L);
      nib = (d == 0) ? b[7:4] : b[3:0];
      tag = (d == 0) ? "R3" : "R4";
      if (cyc == 1)     tag = "R2/R3/R6";
      else if (pos == 0) tag = {tag, "/R6"};
      else if (lo)       tag = {tag, "/R5/R8"};
      else               tag = {tag, "/R7"};
      tag = {pfx, tag};
      chk(k, tag, cyc, {nib, !(lo && d == 0), !(lo && d == 1), 1'b1, 1'b0});
      if (cyc == total) req[k] = 1'b0;
      @(negedge clk);
    end
    chk(k, {pfx, "R9/R10"}, total + 1, {4'hF, 1'b1, 1'b1, 1'b0, 1'b1});
    if (tail) begin
      @(negedge clk);
      chk(k, {pfx, "R9/R11"}, total + 2, {4'hF, 1'b1, 1'b1, 1'b0, 1'b0});
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(0, "R1", 0, 8'hF0 | 8'h0C);
    chk(1, "R1", 0, 8'hFC);
    rst_n = 1'b1;
    @(negedge clk);
    chk(0, "R1", 1, 8'hFC);
    chk(1, "R1", 1, 8'hFC);
  endtask

  task automatic t_idle_gap();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(0, "R10", i, 8'hFC);
      chk(1, "R10", i, 8'hFC);
    end
  endtask

  task automatic t_basic();
    write_seq(0, 8'h37, "", 1'b0, 1'b1);
    write_seq(0, 8'h90, "", 1'b0, 1'b1);
    write_seq(0, 8'h05, "", 1'b0, 1'b1);
  endtask

  task automatic t_min_width();
    write_seq(1, 8'h42, "R8min/", 1'b0, 1'b1);
    write_seq(1, 8'h99, "R8min/", 1'b0, 1'b1);
  endtask

  task automatic t_ignore();
    write_seq(0, 8'h61, "R11/", 1'b1, 1'b1);
    write_seq(1, 8'h28, "R11/", 1'b1, 1'b1);
  endtask

  task automatic t_back_to_back();
    write_seq(0, 8'h12, "R12/", 1'b0, 1'b0);
    write_seq(0, 8'h84, "R12/", 1'b0, 1'b1);
    write_seq(1, 8'h70, "R12/", 1'b0, 1'b0);
    write_seq(1, 8'h36, "R12/", 1'b0, 1'b1);
  endtask

  initial begin
    req[0] = 1'b0; req[1] = 1'b0;
    wb[0]  = 8'h00; wb[1] = 8'h00;
    t_reset();
    t_idle_gap();
    t_basic();
    t_min_width();
    t_ignore();
    t_back_to_back();
    t_idle_gap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule